// File: doc/BRIEF.md
# Vector Immediate Permute Unit

This block is the execute stage for four permute operations whose lane selection comes from an 8-bit immediate held in the instruction word. Each cycle it takes a 32-bit instruction word, a 256-bit source register value and a 256-bit old destination value. It decodes the operation and register indices and, one clock later, presents the new destination value with a valid flag. Register file reads, write-back and pipeline control belong to the surrounding core.

The instruction word holds a 14-bit opcode in bits [31:18], the immediate in [17:10], the source index in [9:5] and the destination index in [4:0]. There are four operation kinds, named in the RTL as `OP_W128`, `OP_W256`, `OP_D256` and `OP_Q256`, plus `OP_NONE` for an unknown opcode. The word forms pick the two low result lanes from the source and the two high result lanes from the old destination. The doubleword form picks every lane from the source. The quadword form picks two 128-bit lanes from a pool built from both registers. All lanes are computed from the values presented at the inputs, so a source index equal to the destination index needs no special handling.

The unit holds no state beyond its output register. Every cycle it loads the decoded result of the current inputs.

Top module: `vperm_imm_unit`

## Requirements
- R1: Opcodes are 0x1cf9 for `OP_W128`, 0x1df9 for `OP_W256`, 0x1dfa for `OP_D256` and 0x1dfb for `OP_Q256`. For any of these, `valid_o` is 1. For every instruction, `src_idx_o` shows bits [9:5] and `dst_idx_o` shows bits [4:0]. The word 0x73E46C22 decodes as `OP_W128` with immediate 0x1B, source index 1 and destination index 2.
- R2: In `OP_W128`, selector k is imm[2k+1:2k]. Result words 0 and 1 are source words sel0 and sel1. Result words 2 and 3 are old-destination words sel2 and sel3. Words are 32 bits, and word 0 is bits [31:0].
- R3: In `OP_W128`, result bits [255:128] are zero.
- R4: `OP_W256` applies the R2 rule to each 128-bit half separately. The upper half reads words 4 to 7, that is, each selector plus 4.
- R5: In `OP_D256`, result doubleword i (64 bits, i = 0..3) is source doubleword imm[2i+1:2i].
- R6: In `OP_Q256`, the pool is {old destination, source}, with the source as quadwords 0 and 1. Result quadword 0 (bits [127:0]) is pool quadword imm[1:0]. Result quadword 1 is pool quadword imm[5:4].
- R7: In `OP_Q256`, immediate bits [3:2] and [7:6] have no effect on the result.
- R8: An opcode matching none of the four gives `valid_o` = 0 and a result equal to the old destination value.
- R9: The outputs reflect the inputs of the previous clock edge. A new instruction can be accepted every cycle, including one whose source and old destination values are the same.
- R10: While `rst_n` is low, `valid_o`, `result_o` and both index outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word |
| src_i | input | 256 | Source register value |
| dst_old_i | input | 256 | Old destination register value |
| result_o | output | 256 | New destination value |
| valid_o | output | 1 | Decoded opcode was one of the four operations |
| src_idx_o | output | 5 | Decoded source register index |
| dst_idx_o | output | 5 | Decoded destination register index |

## Verification
The bench aims at the lanes that read the old destination rather than the source. A design that took all word lanes from the source would corrupt words 2, 3, 6 and 7. The upper half of `OP_W256` is run with selectors that would wrap into the lower half if the +4 offset were missing. The quadword form is applied twice with the same used bits and different ignored bits, and the pool order is checked with selectors that reach both registers, which exposes a swapped concatenation. Near-miss opcodes must drop `valid_o` and pass the old destination through rather than zero or a stale result.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

    localparam int INSTR_W  = 32;
    localparam int VEC_W    = 256;
    localparam int HALF_W   = VEC_W / 2;
    localparam int WORD_W   = 32;
    localparam int DWORD_W  = 64;
    localparam int QWORD_W  = 128;
    localparam int OPC_W    = 14;
    localparam int IMM_W    = 8;
    localparam int IDX_W    = 5;

    localparam logic [OPC_W-1:0] OPC_W128 = 14'h1cf9;
    localparam logic [OPC_W-1:0] OPC_W256 = 14'h1df9;
    localparam logic [OPC_W-1:0] OPC_D256 = 14'h1dfa;
    localparam logic [OPC_W-1:0] OPC_Q256 = 14'h1dfb;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_W128 = 3'd1,
        OP_W256 = 3'd2,
        OP_D256 = 3'd3,
        OP_Q256 = 3'd4
    } perm_op_e;

    typedef struct packed {
        perm_op_e             op;
        logic [IMM_W-1:0]     imm;
        logic [IDX_W-1:0]     src_idx;
        logic [IDX_W-1:0]     dst_idx;
    } perm_dec_t;

endpackage

// File: rtl/vperm_decode.sv
module vperm_decode
    import vperm_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output perm_dec_t          dec_o
);

    logic [OPC_W-1:0] opc;

    assign opc = instr_i[INSTR_W-1 -: OPC_W];

    always_comb begin
        dec_o.imm     = instr_i[17:10];
        dec_o.src_idx = instr_i[9:5];
        dec_o.dst_idx = instr_i[4:0];
        unique case (opc)
            OPC_W128: dec_o.op = OP_W128;
            OPC_W256: dec_o.op = OP_W256;
            OPC_D256: dec_o.op = OP_D256;
            OPC_Q256: dec_o.op = OP_Q256;
            default:  dec_o.op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/vperm_lane_pick.sv
// Picks N_OUT lanes of LANE_W bits from a pool of POOL_N lanes. Lane k uses
// the 2-bit selector sel_i[2k+1:2k]; lanes at or above SPLIT add HI_BASE.
module vperm_lane_pick #(
    parameter int LANE_W  = 32,
    parameter int N_OUT   = 4,
    parameter int POOL_N  = 8,
    parameter int SPLIT   = 2,
    parameter int HI_BASE = 4
) (
    input  logic [POOL_N*LANE_W-1:0] pool_i,
    input  logic [2*N_OUT-1:0]       sel_i,
    output logic [N_OUT*LANE_W-1:0]  res_o
);

    localparam int PIDX_W = (POOL_N > 1) ? $clog2(POOL_N) : 1;

    for (genvar k = 0; k < N_OUT; k++) begin : g_lane
        localparam int BASE = (k >= SPLIT) ? HI_BASE : 0;
        logic [PIDX_W-1:0] idx;
        assign idx = PIDX_W'(int'(sel_i[2*k +: 2]) + BASE);
        assign res_o[k*LANE_W +: LANE_W] = pool_i[int'(idx)*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/vperm_datapath.sv
module vperm_datapath
    import vperm_pkg::*;
(
    input  perm_dec_t         dec_i,
    input  logic [VEC_W-1:0]  src_i,
    input  logic [VEC_W-1:0]  dst_old_i,
    output logic [VEC_W-1:0]  result_o,
    output logic              valid_o
);

    localparam int HALVES   = VEC_W / HALF_W;
    localparam int WPH      = HALF_W / WORD_W;
    localparam int N_DWORD  = VEC_W / DWORD_W;
    localparam int N_QOUT   = VEC_W / QWORD_W;
    localparam int N_QPOOL  = 2 * N_QOUT;

    logic [VEC_W-1:0] word_res;
    logic [VEC_W-1:0] dword_res;
    logic [VEC_W-1:0] qword_res;
    logic [2*N_QOUT-1:0] qsel;

    // Word forms: each half selects from {old half, source half}.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        vperm_lane_pick #(
            .LANE_W (WORD_W),
            .N_OUT  (WPH),
            .POOL_N (2 * WPH),
            .SPLIT  (WPH / 2),
            .HI_BASE(WPH)
        ) u_words (
            .pool_i ({dst_old_i[h*HALF_W +: HALF_W], src_i[h*HALF_W +: HALF_W]}),
            .sel_i  (dec_i.imm),
            .res_o  (word_res[h*HALF_W +: HALF_W])
        );
    end

    // Doubleword form: every lane from the source.
    vperm_lane_pick #(
        .LANE_W (DWORD_W),
        .N_OUT  (N_DWORD),
        .POOL_N (N_DWORD),
        .SPLIT  (N_DWORD),
        .HI_BASE(0)
    ) u_dwords (
        .pool_i (src_i),
        .sel_i  (dec_i.imm),
        .res_o  (dword_res)
    );

    // Quadword form: selectors are imm[1:0] and imm[5:4].
    assign qsel = {dec_i.imm[5:4], dec_i.imm[1:0]};

    vperm_lane_pick #(
        .LANE_W (QWORD_W),
        .N_OUT  (N_QOUT),
        .POOL_N (N_QPOOL),
        .SPLIT  (N_QOUT),
        .HI_BASE(0)
    ) u_qwords (
        .pool_i ({dst_old_i, src_i}),
        .sel_i  (qsel),
        .res_o  (qword_res)
    );

    always_comb begin
        unique case (dec_i.op)
            OP_W128: begin
                result_o = {{(VEC_W-HALF_W){1'b0}}, word_res[HALF_W-1:0]};
                valid_o  = 1'b1;
            end
            OP_W256: begin
                result_o = word_res;
                valid_o  = 1'b1;
            end
            OP_D256: begin
                result_o = dword_res;
                valid_o  = 1'b1;
            end
            OP_Q256: begin
                result_o = qword_res;
                valid_o  = 1'b1;
            end
            default: begin
                result_o = dst_old_i;
                valid_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vperm_imm_unit.sv
module vperm_imm_unit
    import vperm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         instr_i,
    input  logic [255:0]        src_i,
    input  logic [255:0]        dst_old_i,
    output logic [255:0]        result_o,
    output logic                valid_o,
    output logic [4:0]          src_idx_o,
    output logic [4:0]          dst_idx_o
);

    perm_dec_t          dec;
    logic [VEC_W-1:0]   res_d;
    logic               valid_d;

    vperm_decode u_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    vperm_datapath u_datapath (
        .dec_i     (dec),
        .src_i     (src_i),
        .dst_old_i (dst_old_i),
        .result_o  (res_d),
        .valid_o   (valid_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            valid_o   <= 1'b0;
            src_idx_o <= '0;
            dst_idx_o <= '0;
        end else begin
            result_o  <= res_d;
            valid_o   <= valid_d;
            src_idx_o <= dec.src_idx;
            dst_idx_o <= dec.dst_idx;
        end
    end

endmodule

// File: rtl/vperm_imm_unit_chk.sv
module vperm_imm_unit_chk (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [31:0]  instr_i,
    input  logic [255:0] src_i,
    input  logic [255:0] dst_old_i,
    input  logic [255:0] result_o,
    input  logic         valid_o,
    input  logic [4:0]   src_idx_o,
    input  logic [4:0]   dst_idx_o
);

    logic [13:0] opc;
    logic        known;
    logic        is_w128;

    assign opc     = instr_i[31:18];
    assign is_w128 = (opc == 14'h1cf9);
    assign known   = is_w128 || (opc == 14'h1df9) || (opc == 14'h1dfa) || (opc == 14'h1dfb);

    AST_INDEX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (src_idx_o == $past(instr_i[9:5]) && dst_idx_o == $past(instr_i[4:0]))); // R1

    AST_KNOWN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        known |=> valid_o); // R1

    AST_W128_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        is_w128 |=> (result_o[255:128] == '0)); // R3

    AST_UNKNOWN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !known |=> (!valid_o && result_o == $past(dst_old_i))); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!valid_o && result_o == '0)); // R10

endmodule

bind vperm_imm_unit vperm_imm_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_i   (instr_i),
    .src_i     (src_i),
    .dst_old_i (dst_old_i),
    .result_o  (result_o),
    .valid_o   (valid_o),
    .src_idx_o (src_idx_o),
    .dst_idx_o (dst_idx_o)
);

// File: tb/vperm_imm_unit_test.sv
`timescale 1ns/1ps
module vperm_imm_unit_test;

    typedef struct packed {
        logic         v;
        logic [255:0] r;
        logic [4:0]   rs;
        logic [4:0]   rd;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  instr_i = '0;
    logic [255:0] src_i = '0;
    logic [255:0] dst_old_i = '0;
    logic [255:0] result_o;
    logic         valid_o;
    logic [4:0]   src_idx_o;
    logic [4:0]   dst_idx_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 0;

    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    vperm_imm_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .src_i(src_i),
        .dst_old_i(dst_old_i), .result_o(result_o), .valid_o(valid_o),
        .src_idx_o(src_idx_o), .dst_idx_o(dst_idx_o)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [31:0] ins, input logic [255:0] s,
                                   input logic [255:0] o);
        exp_t e;
        logic [7:0] imm;
        int sel;
        logic [511:0] pool;
        imm  = ins[17:10];
        e.rs = ins[9:5];
        e.rd = ins[4:0];
        e.r  = '0;
        e.v  = 1'b1;
        case (ins[31:18])
            14'h1cf9, 14'h1df9: begin
                for (int h = 0; h < ((ins[31:18] == 14'h1df9) ? 2 : 1); h++) begin
                    for (int k = 0; k < 4; k++) begin
                        sel = int'((imm >> (2 * k)) & 8'd3) + 4 * h;
                        if (k < 2) e.r[(4*h+k)*32 +: 32] = s[sel*32 +: 32];
                        else       e.r[(4*h+k)*32 +: 32] = o[sel*32 +: 32];
                    end
                end
            end
            14'h1dfa: begin
                for (int k = 0; k < 4; k++) begin
                    sel = int'((imm >> (2 * k)) & 8'd3);
                    e.r[k*64 +: 64] = s[sel*64 +: 64];
                end
            end
            14'h1dfb: begin
                pool = {o, s};
                e.r[127:0]   = pool[int'(imm[1:0])*128 +: 128];
                e.r[255:128] = pool[int'(imm[5:4])*128 +: 128];
            end
            default: begin
                e.v = 1'b0;
                e.r = o;
            end
        endcase
        return e;
    endfunction

    function automatic logic [255:0] pattern(input logic [7:0] seed);
        logic [255:0] p;
        for (int w = 0; w < 8; w++)
            p[w*32 +: 32] = {seed, 8'(w), ~seed, 8'(8'hA0 + w)};
        return p;
    endfunction

    task automatic drive(input logic [31:0] ins, input logic [255:0] s,
                         input logic [255:0] o, input string tag);
        @(negedge clk);
        instr_i   = ins;
        src_i     = s;
        dst_old_i = o;
        exp_q.push_back(model(ins, s, o));
        tag_q.push_back(tag);
    endtask

    function automatic logic [31:0] mk(input logic [13:0] opc, input logic [7:0] imm,
                                       input logic [4:0] rs, input logic [4:0] rd);
        return {opc, imm, rs, rd};
    endfunction

    task automatic summary;
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        end
        $finish;
    endtask

    // Monitor: compares each registered result a quarter period after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (valid_o !== e.v || result_o !== e.r || src_idx_o !== e.rs || dst_idx_o !== e.rd) begin
                    n_fail++;
                    $display("FAIL %s: got v=%b rs=%0d rd=%0d r=%h expected v=%b rs=%0d rd=%0d r=%h",
                             t, valid_o, src_idx_o, dst_idx_o, result_o, e.v, e.rs, e.rd, e.r);
                end
            end
        end
    end

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [255:0] a, b;
        a = pattern(8'h11);
        b = pattern(8'h77);

        // R10: outputs clear while reset is held.
        repeat (3) @(posedge clk);
        #5;
        n_checks++;
        if (valid_o !== 1'b0 || result_o !== '0 || src_idx_o !== '0 || dst_idx_o !== '0) begin
            n_fail++;
            $display("FAIL R10: got v=%b r=%h expected v=0 r=0", valid_o, result_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        drive(32'h73E46C22, a, b, "R1 check word");
        drive(mk(14'h1cf9, 8'hE4, 5'd7, 5'd9), a, b, "R2 identity selectors");
        drive(mk(14'h1cf9, 8'h5A, 5'd3, 5'd3), a, b, "R2 mixed selectors");
        drive(mk(14'h1cf9, 8'hFF, 5'd31, 5'd0), b, a, "R3 upper zero");
        drive(mk(14'h1df9, 8'h2B, 5'd1, 5'd2), a, b, "R4 per-half 0x2B");
        drive(mk(14'h1df9, 8'hFF, 5'd4, 5'd5), a, b, "R4 upper half top word");
        drive(mk(14'h1dfa, 8'h3B, 5'd1, 5'd2), a, b, "R5 dword 0x3B");
        drive(mk(14'h1dfa, 8'h1B, 5'd6, 5'd8), b, a, "R5 dword reverse");
        drive(mk(14'h1dfb, 8'h4B, 5'd1, 5'd2), a, b, "R6 quad 0x4B");
        drive(mk(14'h1dfb, 8'h21, 5'd2, 5'd1), a, b, "R6 quad 0x21");
        drive(mk(14'h1dfb, 8'h03, 5'd1, 5'd2), a, b, "R7 ignored bits clear");
        drive(mk(14'h1dfb, 8'hCF, 5'd1, 5'd2), a, b, "R7 ignored bits set");
        drive(mk(14'h1cfa, 8'h1B, 5'd1, 5'd2), a, b, "R8 near-miss opcode");
        drive(32'h0000_0000, b, a, "R8 zero word");
        drive(mk(14'h1df8, 8'hAA, 5'd9, 5'd10), a, b, "R8 below W256");
        drive(mk(14'h1cf9, 8'h1B, 5'd4, 5'd4), a, a, "R9 same register");
        drive(mk(14'h1dfb, 8'h31, 5'd4, 5'd4), b, b, "R9 same register quad");
        for (int i = 0; i < 8; i++) begin
            logic [13:0] opc;
            opc = (i % 4 == 0) ? 14'h1cf9 : (i % 4 == 1) ? 14'h1df9 :
                  (i % 4 == 2) ? 14'h1dfa : 14'h1dfb;
            drive(mk(opc, 8'(37 * i + 5), 5'(i), 5'(31 - i)),
                  pattern(8'(i * 13)), pattern(8'(i * 29 + 3)), "R9 back-to-back");
        end

        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        #6;
        summary();
    end

endmodule